// File: doc/BRIEF.md
# Tensor-Scalar Instruction Bundle Validator

The validator takes one 64-byte instruction bundle of the tensor-scalar family, one byte per cycle, over a valid/ready stream. As the bytes arrive it keeps only the header and the control bytes. After the last byte it picks a field layout from the opcode: a symmetric 3-D layout, a three-operand 2-D layout, or an addressable-scalar 2-D layout. It pulls the control fields out of their opcode-dependent positions and checks the legality rules.

The result is a decoded control record with a one-hot error vector. A downstream issue stage reads both and acknowledges them with `out_ready`. The validator accepts no new byte until the record has been taken. The access-pattern descriptor bytes are counted but not kept.

Top module: `tsv_bundle_check`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0. A byte is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `out_valid` rises in the cycle after the 64th byte is accepted. While `out_valid` is 1, `in_ready` is 0 and the record and error vector hold steady. On an edge where `out_ready` is 1, `out_valid` clears and `in_ready` returns.
- R2: If header byte 1 is not 0x10, error bit 1 is raised. If header byte 2 or byte 3 is non-zero, error bit 2 is raised.
- R3: The opcode is byte 0 and is always reported in `rec_opcode`. Layout code 1 (symmetric 3-D) covers opcodes 0x30, 0x43, 0x53, 0x93, 0x9A and 0xE6. Layout code 2 (three-operand) covers 0x9D, 0x9E and 0xE5. Layout code 3 (addressable) covers 0x74. Any other opcode gives layout 0, error bit 0, and zero in every other record field.
- R4: Layout 1 field positions are: accumulate 0x0C, input dtype 0x20, output dtype 0x21, channels 0x22, scalar0 slot 0x23, op0 0x24, op1 0x25, reverse byte 0x26, scalar1 slot 0x27. `rec_dt_a` and `rec_dt_b` are 0.
- R5: Layout 2 field positions are: op0 0x24, op1 0x25, reverse 0x26, scalar slot 0x27 (reported as scalar0), output dtype 0x29, channels 0x2A, scalar dtype 0x2B (reported in `rec_dt_b`), accumulate 0x2C. Byte 0x28 splits into the tensor0 dtype (low nibble, reported as input dtype) and the tensor1 dtype (high nibble, reported in `rec_dt_a`). The scalar1 slot is 0.
- R6: Layout 3 field positions are as follows. Byte 0x28 splits into the scalar0 dtype (low nibble, `rec_dt_a`) and the scalar1 dtype (high nibble, `rec_dt_b`). Byte 0x29 splits into the input dtype (low nibble) and the output dtype (high nibble). The remaining fields are scalar0 slot 0x2A, scalar1 slot 0x2B, op0 0x2C, op1 0x2D, channels 0x2E and reverse 0x2F. Nibbles are zero-extended. This layout has no accumulate field, so `rec_acc` reads 0.
- R7: A legal accumulate code is one of 0 (idle), 1 (zero), 2 (add), 3 (zero then add) or 4 (load). Any value above 4 raises error bit 3.
- R8: An op0 or op1 code above 0x1D, or equal to 0x17 or 0x1C, raises error bit 4.
- R9: For opcode 0x30 error bit 5 is raised in three cases: op0 or op1 is non-zero; the whole reverse byte is non-zero; or scalar1 is non-zero while the accumulate code is not 4.
- R10: Only the lowest-numbered violated error bit is reported, so `rec_err` is one-hot. A fully legal bundle gives `rec_err` = 0.
- R11: `rec_rev` is bits [1:0] of the layout's reverse byte. Bit 0 means op0 operands are swapped and bit 1 means op1 operands are swapped, so the values are 0 none, 1 first, 2 second, 3 both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| in_valid | input | 1 | byte on `in_data` is offered |
| in_data | input | 8 | bundle byte, byte 0 first |
| in_ready | output | 1 | validator can take a byte |
| out_valid | output | 1 | record and error vector are presented |
| out_ready | input | 1 | consumer takes the record |
| rec_opcode | output | 8 | opcode byte |
| rec_layout | output | 2 | 0 unsupported, 1 symmetric 3-D, 2 three-operand, 3 addressable |
| rec_acc | output | 8 | accumulate command |
| rec_op0 | output | 8 | first ALU op code |
| rec_op1 | output | 8 | second ALU op code |
| rec_rev | output | 2 | operand swap flags |
| rec_chan | output | 8 | active channel count |
| rec_imm0 | output | 8 | scalar0 slot byte |
| rec_imm1 | output | 8 | scalar1 slot byte |
| rec_dt_in | output | 8 | input (tensor0) dtype |
| rec_dt_out | output | 8 | output dtype |
| rec_dt_a | output | 8 | tensor1 dtype or scalar0 dtype |
| rec_dt_b | output | 8 | scalar dtype or scalar1 dtype |
| rec_err | output | 6 | one-hot error: 0 opcode, 1 length, 2 reserved, 3 accumulate, 4 ALU op, 5 forced fields |

## Verification
The assertions assume that `in_valid` may be raised at any time, and that `out_ready` is only treated as meaningful while `out_valid` is 1. They also assume that the bundle bytes hold their value while `out_valid` is 1, because the decoded record is built from the stored bytes. The stimulus changes inputs only on falling edges and pulses `out_ready` solely while a record is presented. It drops `in_valid` for single cycles inside some bundles, so both the stall case and the back-to-back case occur. Swept bytes always go through the same legal base bundle, so each sweep value is the only rule under test unless a case combines violations on purpose to test the priority order.

// File: rtl/tsv_pkg.sv
package tsv_pkg;

  typedef enum logic [1:0] {
    LAY_NONE  = 2'd0,
    LAY_SYM3D = 2'd1,
    LAY_TRIO  = 2'd2,
    LAY_ADDR  = 2'd3
  } layout_e;

  // Captured byte taps: four header bytes, the accumulate byte, then a
  // sixteen-byte control window.
  localparam int HDR_BYTES = 4;
  localparam int TAP_ACC   = HDR_BYTES;
  localparam int TAP_WIN   = HDR_BYTES + 1;
  localparam int WIN_BYTES = 16;
  localparam int NUM_TAPS  = TAP_WIN + WIN_BYTES;
  localparam int ACC_ADDR  = 12;
  localparam int WIN_ADDR  = 32;

  // Error vector bit positions; a lower index wins.
  localparam int ERR_W     = 6;
  localparam int ERR_OPC   = 0;
  localparam int ERR_LEN   = 1;
  localparam int ERR_RSV   = 2;
  localparam int ERR_ACC   = 3;
  localparam int ERR_ALU   = 4;
  localparam int ERR_FORCE = 5;

  localparam logic [7:0] WORD_LEN = 8'h10;
  localparam logic [7:0] OPC_EXP  = 8'h30;
  localparam logic [7:0] ACC_LOAD = 8'd4;
  localparam logic [7:0] ALU_TOP  = 8'h1D;

  function automatic int tap_addr(input int t);
    if (t < HDR_BYTES) return t;
    if (t == TAP_ACC)  return ACC_ADDR;
    return WIN_ADDR + t - TAP_WIN;
  endfunction

endpackage

// File: rtl/tsv_collect.sv
module tsv_collect
  import tsv_pkg::*;
#(
  parameter int BUNDLE_BYTES = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [7:0]               in_data,
  output logic                     in_ready,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [NUM_TAPS-1:0][7:0] taps
);

  localparam int CNT_W = $clog2(BUNDLE_BYTES);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BUNDLE_BYTES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full_q, full_d;
  logic             take;

  assign in_ready  = !full_q;
  assign out_valid = full_q;
  assign take      = in_valid && !full_q;

  always_comb begin
    cnt_d  = cnt_q;
    full_d = full_q;
    if (take) begin
      if (cnt_q == LAST_IDX) begin
        cnt_d  = '0;
        full_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (full_q && out_ready) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      full_q <= full_d;
    end
  end

  // One register per tapped byte, loaded when its index goes by.
  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    localparam int ADDR = tap_addr(g);
    logic tap_en;
    assign tap_en = take && (cnt_q == CNT_W'(ADDR));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      taps[g] <= '0;
      else if (tap_en) taps[g] <= in_data;
    end
  end

  AST_NO_TAKE_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);                                            // R1
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);                            // R1
  AST_FULL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready));              // R1

endmodule

// File: rtl/tsv_fields.sv
module tsv_fields
  import tsv_pkg::*;
(
  input  logic [7:0]                opcode,
  input  logic [7:0]                acc_byte,
  input  logic [WIN_BYTES-1:0][7:0] win,
  output layout_e                   layout,
  output logic [7:0]                acc,
  output logic [7:0]                op0,
  output logic [7:0]                op1,
  output logic [7:0]                rev_byte,
  output logic [7:0]                chan,
  output logic [7:0]                imm0,
  output logic [7:0]                imm1,
  output logic [7:0]                dt_in,
  output logic [7:0]                dt_out,
  output logic [7:0]                dt_a,
  output logic [7:0]                dt_b
);

  always_comb begin
    unique case (opcode)
      8'h30, 8'h43, 8'h53, 8'h93, 8'h9A, 8'hE6: layout = LAY_SYM3D;
      8'h9D, 8'h9E, 8'hE5:                      layout = LAY_TRIO;
      8'h74:                                    layout = LAY_ADDR;
      default:                                  layout = LAY_NONE;
    endcase
  end

  // win[k] holds bundle byte 0x20 + k.
  always_comb begin
    acc = '0; op0 = '0; op1 = '0; rev_byte = '0; chan = '0;
    imm0 = '0; imm1 = '0; dt_in = '0; dt_out = '0; dt_a = '0; dt_b = '0;
    unique case (layout)
      LAY_SYM3D: begin                                                    // R4
        acc      = acc_byte;
        dt_in    = win[0];
        dt_out   = win[1];
        chan     = win[2];
        imm0     = win[3];
        op0      = win[4];
        op1      = win[5];
        rev_byte = win[6];
        imm1     = win[7];
      end
      LAY_TRIO: begin                                                     // R5
        op0      = win[4];
        op1      = win[5];
        rev_byte = win[6];
        imm0     = win[7];
        dt_in    = {4'h0, win[8][3:0]};
        dt_a     = {4'h0, win[8][7:4]};
        dt_out   = win[9];
        chan     = win[10];
        dt_b     = win[11];
        acc      = win[12];
      end
      LAY_ADDR: begin                                                     // R6
        dt_a     = {4'h0, win[8][3:0]};
        dt_b     = {4'h0, win[8][7:4]};
        dt_in    = {4'h0, win[9][3:0]};
        dt_out   = {4'h0, win[9][7:4]};
        imm0     = win[10];
        imm1     = win[11];
        op0      = win[12];
        op1      = win[13];
        chan     = win[14];
        rev_byte = win[15];
      end
      default: ;                                                          // R3
    endcase
  end

endmodule

// File: rtl/tsv_rules.sv
module tsv_rules
  import tsv_pkg::*;
(
  input  logic [7:0]       opcode,
  input  logic [7:0]       len_byte,
  input  logic [15:0]      rsv_bytes,
  input  layout_e          layout,
  input  logic [7:0]       acc,
  input  logic [7:0]       op0,
  input  logic [7:0]       op1,
  input  logic [7:0]       rev_byte,
  input  logic [7:0]       imm1,
  output logic [ERR_W-1:0] err
);

  function automatic logic alu_ok(input logic [7:0] c);
    return (c <= ALU_TOP) && (c != 8'h17) && (c != 8'h1C);
  endfunction

  logic [ERR_W-1:0] raw;

  always_comb begin
    raw            = '0;
    raw[ERR_OPC]   = (layout == LAY_NONE);                                // R3
    raw[ERR_LEN]   = (len_byte != WORD_LEN);                              // R2
    raw[ERR_RSV]   = (rsv_bytes != '0);                                   // R2
    raw[ERR_ACC]   = (acc > ACC_LOAD);                                    // R7
    raw[ERR_ALU]   = !alu_ok(op0) || !alu_ok(op1);                        // R8
    raw[ERR_FORCE] = (opcode == OPC_EXP) &&                               // R9
                     ((op0 != '0) || (op1 != '0) || (rev_byte != '0) ||
                      ((imm1 != '0) && (acc != ACC_LOAD)));
  end

  // Keep only the lowest-numbered violation.
  always_comb begin
    logic seen;
    seen = 1'b0;
    err  = '0;
    for (int i = 0; i < ERR_W; i++) begin                                 // R10
      err[i] = raw[i] && !seen;
      seen   = seen || raw[i];
    end
  end

endmodule

// File: rtl/tsv_bundle_check.sv
module tsv_bundle_check
  import tsv_pkg::*;
#(
  parameter int BUNDLE_BYTES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] rec_opcode,
  output logic [1:0] rec_layout,
  output logic [7:0] rec_acc,
  output logic [7:0] rec_op0,
  output logic [7:0] rec_op1,
  output logic [1:0] rec_rev,
  output logic [7:0] rec_chan,
  output logic [7:0] rec_imm0,
  output logic [7:0] rec_imm1,
  output logic [7:0] rec_dt_in,
  output logic [7:0] rec_dt_out,
  output logic [7:0] rec_dt_a,
  output logic [7:0] rec_dt_b,
  output logic [5:0] rec_err
);

  logic [NUM_TAPS-1:0][7:0] taps;
  layout_e                  layout;
  logic [7:0]               rev_byte;

  tsv_collect #(.BUNDLE_BYTES(BUNDLE_BYTES)) u_collect (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .taps      (taps)
  );

  tsv_fields u_fields (
    .opcode   (taps[0]),
    .acc_byte (taps[TAP_ACC]),
    .win      (taps[NUM_TAPS-1:TAP_WIN]),
    .layout   (layout),
    .acc      (rec_acc),
    .op0      (rec_op0),
    .op1      (rec_op1),
    .rev_byte (rev_byte),
    .chan     (rec_chan),
    .imm0     (rec_imm0),
    .imm1     (rec_imm1),
    .dt_in    (rec_dt_in),
    .dt_out   (rec_dt_out),
    .dt_a     (rec_dt_a),
    .dt_b     (rec_dt_b)
  );

  tsv_rules u_rules (
    .opcode    (taps[0]),
    .len_byte  (taps[1]),
    .rsv_bytes ({taps[3], taps[2]}),
    .layout    (layout),
    .acc       (rec_acc),
    .op0       (rec_op0),
    .op1       (rec_op1),
    .rev_byte  (rev_byte),
    .imm1      (rec_imm1),
    .err       (rec_err)
  );

  assign rec_opcode = taps[0];
  assign rec_layout = 2'(layout);
  assign rec_rev    = rev_byte[1:0];                                      // R11

  AST_RECORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(rec_err) && $stable(rec_opcode))); // R1
  AST_ERR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(rec_err));                                    // R10
  AST_UNSUP_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && rec_layout == 2'd0) |->
      (rec_err[ERR_OPC] && rec_op0 == '0 && rec_op1 == '0 && rec_acc == '0)); // R3
  AST_ACC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && rec_err == '0) |-> (rec_acc <= ACC_LOAD));             // R7
  AST_ALU_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && rec_err == '0) |->
      (rec_op0 <= ALU_TOP && rec_op0 != 8'h17 && rec_op0 != 8'h1C));     // R8
  AST_EXP_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && rec_err == '0 && rec_opcode == OPC_EXP) |->
      (rec_op0 == '0 && rec_op1 == '0 && rec_rev == 2'd0));             // R9
  AST_ADDR_NO_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && rec_layout == 2'd3) |-> (rec_acc == '0));              // R6

endmodule

// File: tb/test_tsv_bundle_check.sv
`timescale 1ns/1ps
module test_tsv_bundle_check;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, out_ready, in_ready, out_valid;
  logic [7:0] in_data;
  logic [7:0] rec_opcode, rec_acc, rec_op0, rec_op1, rec_chan, rec_imm0, rec_imm1;
  logic [7:0] rec_dt_in, rec_dt_out, rec_dt_a, rec_dt_b;
  logic [1:0] rec_layout, rec_rev;
  logic [5:0] rec_err;

  always #4 clk = ~clk;   // 125 MHz

  tsv_bundle_check i_tsv_bundle_check (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .rec_opcode(rec_opcode), .rec_layout(rec_layout), .rec_acc(rec_acc),
    .rec_op0(rec_op0), .rec_op1(rec_op1), .rec_rev(rec_rev), .rec_chan(rec_chan),
    .rec_imm0(rec_imm0), .rec_imm1(rec_imm1), .rec_dt_in(rec_dt_in),
    .rec_dt_out(rec_dt_out), .rec_dt_a(rec_dt_a), .rec_dt_b(rec_dt_b),
    .rec_err(rec_err)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] bund [64];

  task automatic expect_eq(input string req, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  // Base bundle: pattern bytes with a legal header and legal control fields.
  task automatic build(input logic [7:0] opc, input int seed);
    for (int i = 0; i < 64; i++) bund[i] = 8'((i * 29 + seed) & 255);
    bund[0] = opc; bund[1] = 8'h10; bund[2] = 8'h00; bund[3] = 8'h00;
    bund[8'h0C] = 8'd2; bund[8'h24] = 8'h05; bund[8'h25] = 8'h1D;
    bund[8'h2C] = 8'd3; bund[8'h2D] = 8'h0A;
    if (opc == 8'h30) begin
      bund[8'h24] = 8'h00; bund[8'h25] = 8'h00; bund[8'h26] = 8'h00; bund[8'h27] = 8'h00;
    end
  endtask

  // Reference model written straight from the requirements.
  function automatic logic [127:0] model();
    logic [1:0] lay;
    logic [7:0] a, o0, o1, rv, ch, i0, i1, di, dout, da, db;
    logic [5:0] raw, e;
    logic       op_bad;
    lay = 2'd0; a = 0; o0 = 0; o1 = 0; rv = 0; ch = 0; i0 = 0; i1 = 0;
    di = 0; dout = 0; da = 0; db = 0;
    case (bund[0])
      8'h30, 8'h43, 8'h53, 8'h93, 8'h9A, 8'hE6: lay = 2'd1;
      8'h9D, 8'h9E, 8'hE5: lay = 2'd2;
      8'h74: lay = 2'd3;
      default: lay = 2'd0;
    endcase
    if (lay == 2'd1) begin
      a = bund[12]; di = bund[32]; dout = bund[33]; ch = bund[34]; i0 = bund[35];
      o0 = bund[36]; o1 = bund[37]; rv = bund[38]; i1 = bund[39];
    end else if (lay == 2'd2) begin
      o0 = bund[36]; o1 = bund[37]; rv = bund[38]; i0 = bund[39];
      di = bund[40] & 8'h0F; da = bund[40] >> 4; dout = bund[41];
      ch = bund[42]; db = bund[43]; a = bund[44];
    end else if (lay == 2'd3) begin
      da = bund[40] & 8'h0F; db = bund[40] >> 4; di = bund[41] & 8'h0F;
      dout = bund[41] >> 4; i0 = bund[42]; i1 = bund[43]; o0 = bund[44];
      o1 = bund[45]; ch = bund[46]; rv = bund[47];
    end
    op_bad = (o0 > 29) || (o0 == 23) || (o0 == 28) || (o1 > 29) || (o1 == 23) || (o1 == 28);
    raw = {(bund[0] == 8'h30) && (o0 != 0 || o1 != 0 || rv != 0 || (i1 != 0 && a != 4)),
           op_bad, a > 4, (bund[2] | bund[3]) != 0, bund[1] != 8'h10, lay == 2'd0};
    e = 0;
    for (int k = 5; k >= 0; k--) if (raw[k]) e = 6'(1 << k);
    return {lay, a, o0, o1, rv[1:0], ch, i0, i1, di, dout, da, db, e};
  endfunction

  function automatic logic [127:0] observed();
    return {rec_layout, rec_acc, rec_op0, rec_op1, rec_rev, rec_chan, rec_imm0,
            rec_imm1, rec_dt_in, rec_dt_out, rec_dt_a, rec_dt_b, rec_err};
  endfunction

  // Stream the bundle, check the record, then release it.
  task automatic run(input string req, input bit gaps, input int hold);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (gaps && (i % 9 == 4)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = bund[i];
    end
    @(negedge clk);
    in_valid = 1'b0;
    expect_eq({req, " R1 valid after last byte"}, 128'({out_valid, in_ready}), 128'(2'b10));
    expect_eq({req, " R3 opcode"}, 128'(rec_opcode), 128'(bund[0]));
    expect_eq(req, observed(), model());
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      expect_eq("R1 held record", {observed()[125:0], out_valid, in_ready},
                {model()[125:0], 2'b10});
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    expect_eq("R1 released", 128'({out_valid, in_ready}), 128'(2'b01));
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    expect_eq("R1 reset state", 128'({out_valid, in_ready}), 128'(2'b01));
    rst_n = 1'b1;
    @(negedge clk);

    // R3: every opcode value on a legal base bundle.
    for (int op = 0; op < 256; op++) begin
      build(8'(op), op);
      run("R3 opcode sweep", op % 17 == 0, 0);
    end

    // R4 / R5 / R6: distinct bytes land in the right fields; held records.
    build(8'h93, 5); bund[32] = 8'hA1; bund[33] = 8'hB2; bund[34] = 8'h7F; run("R4 sym3d fields", 1, 3);
    build(8'h9E, 9); bund[40] = 8'h6C; bund[43] = 8'h0B; bund[44] = 8'd4; run("R5 trio fields", 0, 2);
    build(8'h74, 3); bund[40] = 8'h9E; bund[41] = 8'h2D; bund[46] = 8'h40; run("R6 addr fields", 1, 1);

    // R11: reverse byte in each layout.
    for (int r = 0; r < 8; r++) begin
      build(8'h43, r); bund[38] = 8'(r | 8'h10); run("R11 reverse sym3d", 0, 0);
      build(8'hE5, r); bund[38] = 8'(r); run("R11 reverse trio", 0, 0);
      build(8'h74, r); bund[47] = 8'(r << 1); run("R11 reverse addr", 0, 0);
    end

    // R2: header faults.
    build(8'h43, 1); bund[1] = 8'h0F; run("R2 word length", 0, 0);
    build(8'h43, 2); bund[3] = 8'h01; run("R2 reserved byte", 0, 0);
    build(8'h9D, 2); bund[2] = 8'h80; run("R2 reserved byte trio", 0, 0);

    // R7: accumulate codes.
    for (int a = 0; a < 256; a++) begin
      build(8'h9A, a); bund[12] = 8'(a); run("R7 accumulate sym3d", 0, 0);
    end
    for (int a = 0; a < 12; a++) begin
      build(8'hE5, a); bund[44] = 8'(a); run("R7 accumulate trio", 0, 0);
    end
    build(8'h74, 7); bund[12] = 8'hFF; run("R7 addr has no accumulate", 0, 0);

    // R8: ALU op codes.
    for (int c = 0; c < 256; c++) begin
      build(8'h53, c); bund[36] = 8'(c); run("R8 op0 sym3d", 0, 0);
    end
    for (int c = 0; c < 40; c++) begin
      build(8'h74, c); bund[45] = 8'(c); run("R8 op1 addr", 0, 0);
    end

    // R9: forced fields on the exponential opcode.
    build(8'h30, 1); run("R9 legal exp", 0, 0);
    build(8'h30, 1); bund[36] = 8'h01; run("R9 exp op0", 0, 0);
    build(8'h30, 1); bund[37] = 8'h02; run("R9 exp op1", 0, 0);
    build(8'h30, 1); bund[38] = 8'h04; run("R9 exp reverse upper bit", 0, 0);
    build(8'h30, 1); bund[39] = 8'h05; bund[12] = 8'd3; run("R9 exp imm1 not load", 0, 0);
    build(8'h30, 1); bund[39] = 8'h05; bund[12] = 8'd4; run("R9 exp imm1 with load", 0, 0);
    build(8'h43, 1); bund[38] = 8'h03; bund[39] = 8'h05; run("R9 other opcode free", 0, 0);

    // R10: combined violations report only the lowest bit.
    build(8'h30, 4); bund[1] = 8'h11; bund[12] = 8'd9; bund[36] = 8'h1C; run("R10 len over rest", 0, 0);
    build(8'h30, 4); bund[12] = 8'd9; bund[36] = 8'h1C; run("R10 acc over alu", 0, 0);
    build(8'h30, 4); bund[36] = 8'h17; run("R10 alu over forced", 0, 0);
    build(8'h92, 4); bund[1] = 8'h00; run("R10 opcode over all", 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule